// File: doc/BRIEF.md
# Audio Sample Error Concealment Conditioner

This block sits on the sample path between a digital audio receiver and a serial audio output. Each incoming 24-bit sample arrives with a valid strobe, a left/right channel tag, a receive-error flag and a 4-bit auxiliary word-length code. When a sample is marked as errored, a two-bit policy selects one of three actions. The block can repeat the last good sample of that channel, replace the sample with silence, or let the damaged sample through.

After concealment, the sample can be trimmed to the word length carried in the auxiliary code. The trim only takes effect on the de-emphasis path. When de-emphasis is switched off, the untrimmed sample is selected for output. A global mute overrides everything else and forces silence.

The result is registered. It appears one clock after the input strobe, and no backpressure is applied.

Top module: `conceal_cond`

## Requirements
- R1: `out_valid` equals `in_valid` delayed by one clock. An error-free sample with mute off and the trim path not selected appears unchanged on `out_sample` one clock after its strobe.
- R2: With `cfg_hold` = 2'b00, an errored sample is replaced by the most recent error-free sample of the same channel (`in_right` 0 = left, 1 = right).
- R3: Left and right keep separate last-good stores. Each store is cleared to zero by reset and is loaded by every error-free valid sample of its channel, whatever the mute, trim and de-emphasis settings are.
- R4: With `cfg_hold` = 2'b01, an errored sample is output as all zeros.
- R5: With `cfg_hold` = 2'b10 or the reserved code 2'b11, an errored sample is output unchanged.
- R6: With `cfg_trunc` = 1 and `cfg_deemph` = 1, the word length is 24 minus `in_aux`. The `in_aux` lowest bits of the sample are cleared, and trimming is applied after concealment.
- R7: With `cfg_deemph` = 0, `cfg_trunc` has no effect on `out_sample`.
- R8: With `cfg_mute` = 1, every output sample is all zeros, whatever the error policy or trim settings are.
- R9: During and right after reset, `out_valid` is 0 and `out_sample` is zero.
- R10: In a cycle with `in_valid` = 0, `out_sample` keeps its previous value in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample strobe |
| in_sample | input | 24 | Received sample |
| in_right | input | 1 | Channel tag, 1 = right |
| in_err | input | 1 | Receive error on this sample |
| in_aux | input | 4 | Word-length reduction code |
| cfg_hold | input | 2 | Error policy: 00 repeat, 01 zero, 10/11 pass |
| cfg_trunc | input | 1 | Word-length trim enable |
| cfg_mute | input | 1 | Force silence |
| cfg_deemph | input | 1 | Select the de-emphasis (trimmed) path |
| out_valid | output | 1 | Output strobe |
| out_sample | output | 24 | Conditioned sample |

## Verification
The following follow directly from the current inputs and are checked on every cycle:
- the one-cycle strobe delay;
- the zero and pass-through policies;
- the mute override;
- the cleared low bits under trimming;
- the absence of any trim effect when de-emphasis is off;
- output stability on idle cycles.

Repetition of the last good sample depends on history per channel. The bench's sequences are what show it, including:
- the separation between channels;
- store updates while mute is active;
- clearing of the stores by reset;
- the order of concealment ahead of trimming.

// File: rtl/cnc_pkg.sv
package cnc_pkg;
    localparam int SAMPLE_W = 24;
    localparam int AUX_W    = 4;
    localparam int NUM_CH   = 2;

    typedef logic [SAMPLE_W-1:0] sample_t;
    typedef logic [AUX_W-1:0]    aux_t;

    typedef enum logic [1:0] {
        HOLD_REPEAT = 2'b00,
        HOLD_ZERO   = 2'b01,
        HOLD_PASS   = 2'b10,
        HOLD_RSVD   = 2'b11
    } hold_e;

    typedef struct packed {
        logic    right;
        logic    err;
        sample_t data;
    } word_t;

    // Clear the n lowest bits of a sample.
    function automatic sample_t clear_low(sample_t s, aux_t n);
        sample_t keep;
        keep = {SAMPLE_W{1'b1}} << n;
        return s & keep;
    endfunction
endpackage

// File: rtl/conceal_policy.sv
module conceal_policy
    import cnc_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    valid,
    input  word_t   word,
    input  hold_e   mode,
    output sample_t data_out
);
    sample_t last_good [NUM_CH];

    generate
        for (genvar g = 0; g < NUM_CH; g++) begin : g_store
            always_ff @(posedge clk) begin
                if (rst) begin
                    last_good[g] <= '0;
                end else if (valid && !word.err && (word.right == 1'(g))) begin
                    last_good[g] <= word.data;
                end
            end
        end
    endgenerate

    always_comb begin
        data_out = word.data;
        if (word.err) begin
            unique case (mode)
                HOLD_REPEAT: data_out = last_good[word.right];
                HOLD_ZERO:   data_out = '0;
                HOLD_PASS,
                HOLD_RSVD:   data_out = word.data;
            endcase
        end
    end
endmodule

// File: rtl/word_trunc.sv
module word_trunc
    import cnc_pkg::*;
(
    input  logic    en,
    input  aux_t    aux,
    input  sample_t data_in,
    output sample_t data_out
);
    always_comb begin
        data_out = en ? clear_low(data_in, aux) : data_in;
    end
endmodule

// File: rtl/conceal_cond.sv
module conceal_cond
    import cnc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic [23:0] in_sample,
    input  logic        in_right,
    input  logic        in_err,
    input  logic [3:0]  in_aux,
    input  logic [1:0]  cfg_hold,
    input  logic        cfg_trunc,
    input  logic        cfg_mute,
    input  logic        cfg_deemph,
    output logic        out_valid,
    output logic [23:0] out_sample
);
    word_t   word;
    sample_t concealed;
    sample_t trimmed;
    sample_t chosen;

    assign word = '{right: in_right, err: in_err, data: in_sample};

    conceal_policy u_policy (
        .clk      (clk),
        .rst      (rst),
        .valid    (in_valid),
        .word     (word),
        .mode     (hold_e'(cfg_hold)),
        .data_out (concealed)
    );

    // Trim sits on the de-emphasis path only.
    word_trunc u_trunc (
        .en       (cfg_trunc),
        .aux      (in_aux),
        .data_in  (concealed),
        .data_out (trimmed)
    );

    always_comb begin
        if (cfg_mute) begin
            chosen = '0;
        end else if (cfg_deemph) begin
            chosen = trimmed;
        end else begin
            chosen = concealed;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            out_sample <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_sample <= chosen;
            end
        end
    end
endmodule

// File: rtl/conceal_cond_chk.sv
module conceal_cond_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic [23:0] in_sample,
    input logic        in_err,
    input logic [3:0]  in_aux,
    input logic [1:0]  cfg_hold,
    input logic        cfg_trunc,
    input logic        cfg_mute,
    input logic        cfg_deemph,
    input logic        out_valid,
    input logic [23:0] out_sample
);
    logic [23:0] low_bits;
    assign low_bits = (24'h1 << in_aux) - 24'h1;

    // R1
    strobe_delay_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid == $past(in_valid));

    // R1
    clean_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_err && !cfg_mute && !cfg_deemph) |=> out_sample == $past(in_sample));

    // R4
    zero_policy_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_err && cfg_hold == 2'b01) |=> out_sample == 24'h0);

    // R5
    pass_policy_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_err && cfg_hold[1] && !cfg_mute && !cfg_deemph) |=> out_sample == $past(in_sample));

    // R6
    trim_low_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && cfg_trunc && cfg_deemph) |=> (out_sample & $past(low_bits)) == 24'h0);

    // R7
    trim_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && cfg_trunc && !cfg_deemph && !in_err && !cfg_mute) |=> out_sample == $past(in_sample));

    // R8
    mute_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && cfg_mute) |=> out_sample == 24'h0);

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_sample));

    // R9
    always @(posedge clk) begin
        if (!rst && $past(rst)) begin
            reset_state_chk: assert (!out_valid && out_sample == 24'h0);
        end
    end
endmodule

bind conceal_cond conceal_cond_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_sample  (in_sample),
    .in_err     (in_err),
    .in_aux     (in_aux),
    .cfg_hold   (cfg_hold),
    .cfg_trunc  (cfg_trunc),
    .cfg_mute   (cfg_mute),
    .cfg_deemph (cfg_deemph),
    .out_valid  (out_valid),
    .out_sample (out_sample)
);

// File: tb/test_conceal_cond.sv
`timescale 1ns/1ps
module test_conceal_cond;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [23:0] in_sample;
    logic        in_right;
    logic        in_err;
    logic [3:0]  in_aux;
    logic [1:0]  cfg_hold;
    logic        cfg_trunc;
    logic        cfg_mute;
    logic        cfg_deemph;
    logic        out_valid;
    logic [23:0] out_sample;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    conceal_cond i_conceal_cond (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
        .in_right(in_right), .in_err(in_err), .in_aux(in_aux),
        .cfg_hold(cfg_hold), .cfg_trunc(cfg_trunc), .cfg_mute(cfg_mute),
        .cfg_deemph(cfg_deemph), .out_valid(out_valid), .out_sample(out_sample)
    );

    typedef struct packed {
        logic        right;
        logic        err;
        logic [1:0]  hold;
        logic [3:0]  aux;
        logic        trunc;
        logic        deemph;
        logic        mute;
        logic [23:0] sample;
        logic [23:0] expect_out;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t TBL [NV] = '{
        '{1'b0, 1'b0, 2'b00, 4'd0,  1'b0, 1'b0, 1'b0, 24'h123456, 24'h123456, 8'd1}, // R1
        '{1'b1, 1'b0, 2'b00, 4'd0,  1'b0, 1'b0, 1'b0, 24'hABCDEF, 24'hABCDEF, 8'd1}, // R1
        '{1'b0, 1'b1, 2'b00, 4'd0,  1'b0, 1'b0, 1'b0, 24'h111111, 24'h123456, 8'd2}, // R2
        '{1'b1, 1'b1, 2'b00, 4'd0,  1'b0, 1'b0, 1'b0, 24'h222222, 24'hABCDEF, 8'd3}, // R3
        '{1'b0, 1'b1, 2'b01, 4'd0,  1'b0, 1'b0, 1'b0, 24'h333333, 24'h000000, 8'd4}, // R4
        '{1'b1, 1'b1, 2'b10, 4'd0,  1'b0, 1'b0, 1'b0, 24'h444444, 24'h444444, 8'd5}, // R5
        '{1'b0, 1'b1, 2'b11, 4'd0,  1'b0, 1'b0, 1'b0, 24'h555555, 24'h555555, 8'd5}, // R5
        '{1'b0, 1'b0, 2'b00, 4'd0,  1'b0, 1'b0, 1'b0, 24'h0F0F0F, 24'h0F0F0F, 8'd2}, // R2
        '{1'b0, 1'b1, 2'b00, 4'd0,  1'b0, 1'b0, 1'b0, 24'h999999, 24'h0F0F0F, 8'd2}, // R2
        '{1'b0, 1'b0, 2'b00, 4'd4,  1'b1, 1'b1, 1'b0, 24'hFFFFFF, 24'hFFFFF0, 8'd6}, // R6
        '{1'b1, 1'b0, 2'b00, 4'd15, 1'b1, 1'b1, 1'b0, 24'hFFFFFF, 24'hFF8000, 8'd6}, // R6
        '{1'b1, 1'b0, 2'b00, 4'd0,  1'b1, 1'b1, 1'b0, 24'hFFFFFF, 24'hFFFFFF, 8'd6}, // R6
        '{1'b0, 1'b0, 2'b00, 4'd8,  1'b1, 1'b0, 1'b0, 24'hABCDEF, 24'hABCDEF, 8'd7}, // R7
        '{1'b0, 1'b1, 2'b00, 4'd8,  1'b1, 1'b1, 1'b0, 24'h888888, 24'hABCD00, 8'd6}, // R6
        '{1'b1, 1'b0, 2'b00, 4'd0,  1'b0, 1'b0, 1'b1, 24'h777777, 24'h000000, 8'd8}, // R8
        '{1'b1, 1'b1, 2'b00, 4'd0,  1'b0, 1'b0, 1'b0, 24'h666666, 24'h777777, 8'd3}, // R3
        '{1'b0, 1'b1, 2'b10, 4'd0,  1'b1, 1'b1, 1'b1, 24'h5A5A5A, 24'h000000, 8'd8}  // R8
    };

    task automatic check(string req, logic [23:0] act, logic [23:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(logic v, logic r, logic e, logic [1:0] h, logic [3:0] a,
                         logic t, logic d, logic m, logic [23:0] s);
        in_valid = v; in_right = r; in_err = e; cfg_hold = h; in_aux = a;
        cfg_trunc = t; cfg_deemph = d; cfg_mute = m; in_sample = s;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        drive(1'b0, 1'b0, 1'b0, 2'b00, 4'd0, 1'b0, 1'b0, 1'b0, 24'h0);
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        rst = 1'b1;
        drive(1'b0, 1'b0, 1'b0, 2'b00, 4'd0, 1'b0, 1'b0, 1'b0, 24'h0);
        repeat (3) @(negedge clk);
        // R9: reset state
        check("R9 valid", {23'h0, out_valid}, 24'h0);
        check("R9 sample", out_sample, 24'h0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            drive(1'b1, TBL[i].right, TBL[i].err, TBL[i].hold, TBL[i].aux,
                  TBL[i].trunc, TBL[i].deemph, TBL[i].mute, TBL[i].sample);
            @(negedge clk);
            check($sformatf("R1 strobe row %0d", i), {23'h0, out_valid}, 24'h1);
            check($sformatf("R%0d row %0d", TBL[i].req, i), out_sample, TBL[i].expect_out);
        end

        // R10: idle cycles keep the last output
        drive(1'b1, 1'b0, 1'b0, 2'b00, 4'd0, 1'b0, 1'b0, 1'b0, 24'h246810);
        @(negedge clk);
        check("R1 directed", out_sample, 24'h246810);
        drive(1'b0, 1'b1, 1'b1, 2'b01, 4'd3, 1'b1, 1'b1, 1'b1, 24'hDEAD00);
        @(negedge clk);
        check("R1 idle strobe", {23'h0, out_valid}, 24'h0);
        check("R10 hold 1", out_sample, 24'h246810);
        @(negedge clk);
        check("R10 hold 2", out_sample, 24'h246810);

        // R3: reset clears both stores
        do_reset();
        check("R9 after reset", out_sample, 24'h0);
        drive(1'b1, 1'b0, 1'b1, 2'b00, 4'd0, 1'b0, 1'b0, 1'b0, 24'h135791);
        @(negedge clk);
        check("R3 left cleared", out_sample, 24'h0);
        drive(1'b1, 1'b1, 1'b1, 2'b00, 4'd0, 1'b0, 1'b0, 1'b0, 24'h975311);
        @(negedge clk);
        check("R3 right cleared", out_sample, 24'h0);
        drive(1'b0, 1'b0, 1'b0, 2'b00, 4'd0, 1'b0, 1'b0, 1'b0, 24'h0);
        @(negedge clk);

        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule